// File: doc/BRIEF.md
# Double-Buffered DAC Host Interface

This block sits between a host's parallel bus and a 16-bit digital-to-analog converter core. The host selects the block with an active-low select and picks the direction with a read/write line. A write captures the bus word into an input register, and a read drives that register back onto the bus so that software can confirm what it stored. A separate active-low load strobe moves the input register into the converter register. Several converters that share one load line can therefore be updated together.

An active-low clear loads the converter register with a fixed code, chosen by the read/write line. The code is zero when the line is low and midscale when it is high, so the analog output can be set to 0 V in both unipolar and bipolar wiring. Each falling edge of the load strobe raises a hold output for a fixed number of clock cycles. This freezes the analog output stage while the converter settles on its new code.

All control and data inputs pass through a synchroniser of `SYNC_STAGES` flops before they are used. The interface is a strobed register bus, not a stream: there is no valid/ready pair and no back-pressure. The host keeps select and data steady for at least `SYNC_STAGES + 1` clock cycles, and every such cycle is accepted.

Top module: `dacif_top`

## Requirements
- R1: When select (`cs_n`) is high, `bus_oe` is 0 and the block does not drive the bus.
- R2: When `cs_n` is low and `rw` is 0 (write), the word on `bus_in` is stored in the input register.
- R3: When `cs_n` is low and `rw` is 1 (read), `bus_oe` is 1 and `bus_out` carries the input register. It does not carry the converter register.
- R4: A write with `ld_n` high leaves `dac_code` unchanged. A low `ld_n` copies the input register into `dac_code`.
- R5: While `ld_n` is held low, `dac_code` follows each write directly.
- R6: A low `clr_n` sets `dac_code` to 0x0000 when `rw` is 0 and to 0x8000 when `rw` is 1. Clear wins over a load in the same cycle, and it leaves the input register unchanged.
- R7: Each falling edge of `ld_n` holds `hold` high for exactly `HOLD_CYCLES` cycles. A new falling edge while `hold` is high restarts the count.
- R8: When `ld_n` is low from reset onward, `hold` never rises.
- R9: After reset, `dac_code` is 0, the input register is 0, `bus_oe` is 0 and `hold` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select |
| rw | input | 1 | 1 = read, 0 = write; also picks the clear code |
| ld_n | input | 1 | Active-low load strobe |
| clr_n | input | 1 | Active-low clear of the converter register |
| bus_in | input | DATA_W | Bus word from the host |
| bus_out | output | DATA_W | Readback word to the host |
| bus_oe | output | 1 | Bus driver enable for readback |
| dac_code | output | DATA_W | Code presented to the converter core |
| hold | output | 1 | Output-stage hold after a load edge |

## Verification
The bench builds the block with `DATA_W` = 16, `SYNC_STAGES` = 2 and `HOLD_CYCLES` = 8. The short hold lets the bench measure every hold pulse to the exact cycle, including a restart that lands three cycles after the first edge. A sweep of walking-one and walking-zero words, written and read back one by one, covers every data bit in both the input and converter registers. A second reset with the load strobe held low covers the transparent mode and confirms that it produces no hold pulse.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
  localparam int unsigned CTRL_W = 4;
  // Control vector layout after synchronisation.
  localparam int unsigned CI_CS  = 3;
  localparam int unsigned CI_RW  = 2;
  localparam int unsigned CI_LD  = 1;
  localparam int unsigned CI_CLR = 0;
  // Inactive reset levels: select off, write, load asserted, clear off.
  // Load resets to asserted so a strobe tied low never shows an edge.
  localparam logic [CTRL_W-1:0] CTRL_RST = 4'b1001;

  typedef struct packed {
    logic wr;
    logic rd;
    logic ld;
    logic clr;
    logic clr_mid;
  } dacif_cmd_t;
endpackage

// File: rtl/dacif_sync.sv
module dacif_sync #(
  parameter int unsigned WIDTH   = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dacif_regs.sv
module dacif_regs
  import dacif_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dacif_cmd_t        cmd,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] in_q,
  output logic [DATA_W-1:0] dac_q
);
  localparam logic [DATA_W-1:0] MIDSCALE = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] in_nxt;
  logic [DATA_W-1:0] dac_nxt;

  always_comb begin
    in_nxt = cmd.wr ? wdata : in_q;
    if (cmd.clr)
      dac_nxt = cmd.clr_mid ? MIDSCALE : '0;
    else if (cmd.ld)
      dac_nxt = in_nxt;   // transparent path: a write under load lands at once
    else
      dac_nxt = dac_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q  <= '0;
      dac_q <= '0;
    end else begin
      in_q  <= in_nxt;
      dac_q <= dac_nxt;
    end
  end
endmodule

// File: rtl/dacif_hold.sv
module dacif_hold #(
  parameter int unsigned HOLD_CYCLES = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ld_lvl,   // synchronised strobe level, 0 = asserted
  output logic fall,
  output logic hold
);
  localparam int unsigned CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] START = CNT_W'(HOLD_CYCLES);

  logic             prev;
  logic [CNT_W-1:0] cnt;

  assign fall = prev & ~ld_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= 1'b0;
      cnt  <= '0;
    end else begin
      prev <= ld_lvl;
      if (fall)          cnt <= START;
      else if (cnt != 0) cnt <= cnt - 1'b1;
    end
  end

  assign hold = (cnt != 0);
endmodule

// File: rtl/dacif_top.sv
module dacif_top
  import dacif_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HOLD_CYCLES = 250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rw,
  input  logic              ld_n,
  input  logic              clr_n,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  output logic [DATA_W-1:0] dac_code,
  output logic              hold
);
  logic [CTRL_W-1:0] ctrl_raw, ctrl_s;
  logic [DATA_W-1:0] data_s;
  logic [DATA_W-1:0] in_q;
  dacif_cmd_t        cmd;
  logic              ld_fall;
  logic              rd_q;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    ctrl_raw         = '0;
    ctrl_raw[CI_CS]  = cs_n;
    ctrl_raw[CI_RW]  = rw;
    ctrl_raw[CI_LD]  = ld_n;
    ctrl_raw[CI_CLR] = clr_n;
  end

  dacif_sync #(.WIDTH(CTRL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTRL_RST)) u_sync_ctrl (
    .clk(clk), .rst_n(rst_n), .d(ctrl_raw), .q(ctrl_s)
  );

  dacif_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_data (
    .clk(clk), .rst_n(rst_n), .d(bus_in), .q(data_s)
  );

  always_comb begin
    cmd.wr      = ~ctrl_s[CI_CS] & ~ctrl_s[CI_RW];
    cmd.rd      = ~ctrl_s[CI_CS] &  ctrl_s[CI_RW];
    cmd.ld      = ~ctrl_s[CI_LD];
    cmd.clr     = ~ctrl_s[CI_CLR];
    cmd.clr_mid =  ctrl_s[CI_RW];
  end

  dacif_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .wdata(data_s),
    .in_q(in_q), .dac_q(dac_code)
  );

  dacif_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk(clk), .rst_n(rst_n), .ld_lvl(ctrl_s[CI_LD]), .fall(ld_fall), .hold(hold)
  );

  // Registered readback driver.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      rd_q    <= cmd.rd;
      rdata_q <= cmd.rd ? in_q : '0;
    end
  end

  assign bus_oe  = rd_q;
  assign bus_out = rdata_q;
endmodule

// File: rtl/dacif_checker.sv
module dacif_checker #(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned HOLD_CYCLES = 250
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_oe,
  input logic [DATA_W-1:0] bus_out,
  input logic [DATA_W-1:0] in_q,
  input logic [DATA_W-1:0] dac_code,
  input logic              hold,
  input logic              ld_fall,
  input dacif_pkg::dacif_cmd_t cmd
);
  localparam logic [DATA_W-1:0] MIDSCALE = {1'b1, {(DATA_W-1){1'b0}}};
  localparam int unsigned RUN_W = $clog2(HOLD_CYCLES + 2) + 1;

  logic [RUN_W-1:0] run;
  logic             seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= '0;
      seen <= 1'b0;
    end else begin
      seen <= 1'b1;
      if (ld_fall)   run <= '0;
      else if (hold) run <= run + 1'b1;
      else           run <= '0;
    end
  end

  // R3: the readback word is the input register as it stood one cycle earlier
  p_readback_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    seen && bus_oe |-> bus_out == $past(in_q));

  // R6: clear loads the code chosen by the read/write line
  p_clear_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.clr |=> dac_code == ($past(cmd.clr_mid) ? MIDSCALE : '0));

  // R6: clear without a write leaves the input register alone
  p_clear_keeps_in_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.clr && !cmd.wr |=> $stable(in_q));

  // R4: with neither load nor clear the converter code holds
  p_no_load_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd.ld && !cmd.clr |=> $stable(dac_code));

  // R7: a load edge raises hold on the next cycle
  p_hold_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fall |=> hold);

  // R7: a hold run never outlasts the configured length
  p_hold_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    run <= RUN_W'(HOLD_CYCLES));

  // R1: the bus is never driven without a read
  p_bus_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd.rd |=> !bus_oe);
endmodule

bind dacif_top dacif_checker #(.DATA_W(DATA_W), .HOLD_CYCLES(HOLD_CYCLES)) u_dacif_checker (
  .clk(clk), .rst_n(rst_n), .bus_oe(bus_oe), .bus_out(bus_out), .in_q(in_q),
  .dac_code(dac_code), .hold(hold), .ld_fall(ld_fall), .cmd(cmd)
);

// File: tb/dacif_top_bench.sv
module dacif_top_bench;
  localparam int unsigned DW   = 16;
  localparam int unsigned SS   = 2;
  localparam int unsigned HC   = 8;
  localparam int unsigned SETL = SS + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, rw = 1'b0, ld_n = 1'b1, clr_n = 1'b1;
  logic [DW-1:0] bus_in = '0;
  logic [DW-1:0] bus_out, dac_code;
  logic bus_oe, hold;

  int n_chk = 0, n_bad = 0, hold_cnt = 0;
  logic hold_ever = 1'b0;

  always #10 clk = ~clk;

  dacif_top #(.DATA_W(DW), .SYNC_STAGES(SS), .HOLD_CYCLES(HC)) u_dacif_top (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .ld_n(ld_n), .clr_n(clr_n),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .dac_code(dac_code), .hold(hold)
  );

  always @(negedge clk) begin
    if (hold) begin
      hold_cnt  <= hold_cnt + 1;
      hold_ever <= 1'b1;
    end
  end

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_write(input logic [DW-1:0] v);
    @(negedge clk); cs_n = 1'b0; rw = 1'b0; bus_in = v;
    idle(SS + 1);
    cs_n = 1'b1;
    idle(SETL);
  endtask

  task automatic bus_read(input string req, input logic [DW-1:0] exp);
    @(negedge clk); cs_n = 1'b0; rw = 1'b1;
    idle(SETL);
    chk(req, {15'd0, bus_oe}, 16'd1);
    chk(req, bus_out, exp);
    cs_n = 1'b1; rw = 1'b0;
    idle(SETL);
    chk("R1", {15'd0, bus_oe}, 16'd0);
  endtask

  task automatic ld_pulse;
    @(negedge clk); ld_n = 1'b0;
    idle(2);
    ld_n = 1'b1;
  endtask

  initial begin
    #3_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] prev_dac, v;
    idle(3);
    rst_n = 1'b1;
    idle(SETL);
    // R9: reset state
    chk("R9", dac_code, '0);
    chk("R9", {15'd0, bus_oe}, 16'd0);
    chk("R9", {15'd0, hold}, 16'd0);
    chk("R1", {15'd0, bus_oe}, 16'd0);
    bus_read("R9", '0);

    // R2/R3/R4/R7: walking ones and zeros
    prev_dac = '0;
    for (int k = 0; k < 2 * DW; k++) begin
      v = (k < DW) ? (16'd1 << k) : ~(16'd1 << (k - DW));
      bus_write(v);
      bus_read("R3", v);                  // R2 capture and R3 readback
      chk("R4", dac_code, prev_dac);      // converter still on old code
      hold_cnt = 0;
      ld_pulse();
      idle(HC + SETL + 4);
      chk("R4", dac_code, v);
      chk("R7", 16'(hold_cnt), 16'(HC));
      prev_dac = v;
    end

    // R7: restart three cycles after the first edge
    hold_cnt = 0;
    ld_pulse();
    ld_pulse();
    idle(HC + SETL + 6);
    chk("R7", 16'(hold_cnt), 16'(HC + 3));

    // R6: clear codes and input register untouched
    bus_write(16'h1234);
    @(negedge clk); rw = 1'b1; clr_n = 1'b0;
    idle(2); clr_n = 1'b1; rw = 1'b0;
    idle(SETL);
    chk("R6", dac_code, 16'h8000);
    bus_read("R6", 16'h1234);
    @(negedge clk); rw = 1'b0; clr_n = 1'b0;
    idle(2); clr_n = 1'b1;
    idle(SETL);
    chk("R6", dac_code, 16'h0000);
    // R6: clear beats a simultaneous load
    @(negedge clk); rw = 1'b1; clr_n = 1'b0; ld_n = 1'b0;
    idle(2); clr_n = 1'b1; ld_n = 1'b1; rw = 1'b0;
    idle(HC + SETL);
    chk("R6", dac_code, 16'h8000);
    bus_read("R6", 16'h1234);

    // R8/R5: reset with load tied low
    @(negedge clk); rst_n = 1'b0; ld_n = 1'b0;
    idle(3);
    hold_ever = 1'b0;
    rst_n = 1'b1;
    idle(SETL);
    chk("R9", dac_code, '0);
    for (int k = 0; k < 6; k++) begin
      v = 16'(16'h0F0F * (k + 1) + k);
      bus_write(v);
      chk("R5", dac_code, v);
    end
    chk("R8", {15'd0, hold_ever}, 16'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule